// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects eleven interrupt event pulses for a small 8-bit processor core. It keeps one pending flag per source. Software-written enable bits and a processor-wide global enable gate those flags. When the core signals an instruction boundary, the block picks the most urgent enabled request and starts an acknowledge sequence. That sequence turns the global enable off, clears the flag of the chosen source and presents a fixed ROM vector address for the duration of the automatic call.

Source 1 is the most urgent and source 11 the least. Each source owns a two-byte vector slot at address `2*n`. Address 0x0000 is left to the reset entry. The enable bits are spread over two byte-wide registers. The endpoint register gates sources 4 to 6, and the general register gates the other eight sources. A status byte shows whether any enabled request is waiting, even while the global enable is off, together with the current global enable state.

Top module: `vic_top`

## Requirements
- R1: An event pulse on `evt_i[n-1]` sets the pending flag of source n. The flag stays set until that source is acknowledged or reset is asserted. A flag that is set while its enable is clear becomes visible as soon as the enable is written.
- R2: A source can raise a request only when its enable bit is 1. With `reg_sel_i`=0 the write targets the general register: bits 0..2 enable sources 1..3 and bits 3..7 enable sources 7..11. With `reg_sel_i`=1 the write targets the endpoint register: bits 0..2 enable sources 4..6 and upper bits read as 0. A write takes effect at the next clock edge. `reg_rdata_o` returns the register selected by `reg_sel_i`.
- R3: While `rst_ni` is low, both enable registers, all pending flags and the global enable are cleared. During reset, `ack_o`=0, `vec_o`=0 and `status_o`=0.
- R4: When several enabled requests are pending, the source with the lowest number is the one acknowledged.
- R5: During an acknowledge, `vec_o` equals 2*n for source n, from 0x0002 to 0x0016.
- R6: An acknowledge starts only at a clock edge where `boundary_i`=1, the global enable is 1 and at least one enabled request is pending. That same edge clears the global enable and the pending flag of the chosen source.
- R7: `ack_o` stays high for exactly 10 cycles per acknowledge. `vec_o` is held constant during that time and is 0x0000 whenever `ack_o` is low.
- R8: `ei_i` and `reti_i` set the global enable, and `di_i` clears it. `di_i` wins when it arrives together with either of the other two. An acknowledge start wins over all three.
- R9: `status_o[7]` is 1 whenever any pending flag has its enable set, regardless of the global enable. `status_o[2]` shows the global enable. All other status bits read 0.
- R10: An event pulse arriving in the same cycle as the acknowledge that clears its flag leaves the flag set.
- R11: No acknowledge starts while the global enable is 0, while no enabled request is pending, or while an acknowledge is already running. A `boundary_i` pulse during a running acknowledge does not change `vec_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 11 | Single-cycle event pulses, bit n-1 for source n |
| reg_we_i | input | 1 | Enable register write strobe |
| reg_sel_i | input | 1 | 0: general enable register, 1: endpoint enable register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Selected enable register contents |
| boundary_i | input | 1 | Current instruction completes this cycle |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| reti_i | input | 1 | Return from interrupt, sets global enable |
| ack_o | output | 1 | Acknowledge / automatic call in progress |
| vec_o | output | 16 | ROM vector address during acknowledge, else 0 |
| status_o | output | 8 | Bit 7 IRQ sense, bit 2 global enable |

## Verification
The case that is hardest to reach from the ports is an event for a source arriving in the very cycle its own acknowledge clears it. The stimulus first makes that source pending and enabled with the global enable on. It then drives the same event bit alongside `boundary_i` for one cycle. Afterwards the IRQ-sense bit must still read 1 while the global enable is off, and a RETI followed by a fresh boundary must yield the same vector again. A second hard case is reaching the running acknowledge window with `boundary_i` asserted. This is done by raising `boundary_i` in the middle of the 10-cycle call and checking that the vector stays put.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NUM_SRC   = 11;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned VEC_W     = 16;
  localparam int unsigned CALL_CYC  = 10;
  localparam int unsigned EP_LO     = 3;   // first endpoint source index
  localparam int unsigned EP_W      = 3;
  localparam int unsigned GEN_W     = NUM_SRC - EP_W;
  localparam int unsigned SENSE_BIT = 7;
  localparam int unsigned GIE_BIT   = 2;
  localparam int unsigned CNT_W     = $clog2(CALL_CYC + 1);
endpackage

// File: rtl/vic_pending.sv
module vic_pending
  import vic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q;

  // set beats clear on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/vic_enable_regs.sv
module vic_enable_regs
  import vic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_SRC-1:0] en_o
);
  logic [GEN_W-1:0] gen_q;
  logic [EP_W-1:0]  ep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q <= '0;
      ep_q  <= '0;
    end else if (we_i) begin
      if (sel_i) ep_q  <= wdata_i[EP_W-1:0];
      else       gen_q <= wdata_i[GEN_W-1:0];
    end
  end

  assign rdata_o = sel_i ? DATA_W'(ep_q) : DATA_W'(gen_q);

  // endpoint sources sit in the middle of the priority order
  assign en_o = {gen_q[GEN_W-1:EP_LO], ep_q, gen_q[EP_LO-1:0]};

  p_ep_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> (rdata_o[DATA_W-1:EP_W] == '0));
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic               any_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [NUM_SRC:0] seen;
  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chain
    assign grant_o[gi]  = req_i[gi] & ~seen[gi];
    assign seen[gi + 1] = seen[gi] | req_i[gi];
  end

  assign any_o = seen[NUM_SRC];

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant_o[i]) vec_o = vec_o | VEC_W'(2 * (i + 1));
  end
endmodule

// File: rtl/vic_ack_fsm.sv
module vic_ack_fsm
  import vic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boundary_i,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               reti_i,
  input  logic               any_i,
  input  logic [NUM_SRC-1:0] grant_i,
  input  logic [VEC_W-1:0]   win_vec_i,
  output logic               gie_o,
  output logic               busy_o,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic             gie_q, busy_q, take;
  logic [CNT_W-1:0] cnt_q;
  logic [VEC_W-1:0] vec_q;

  assign take  = boundary_i & gie_q & any_i & ~busy_q;
  assign clr_o = take ? grant_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gie_q <= 1'b0;
    else if (take)            gie_q <= 1'b0;
    else if (di_i)            gie_q <= 1'b0;
    else if (ei_i || reti_i)  gie_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      vec_q  <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CALL_CYC - 1);
      vec_q  <= win_vec_i;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        vec_q  <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign gie_o  = gie_q;
  assign busy_o = busy_q;
  assign vec_o  = vec_q;

  // checker-side count of acknowledge length
  logic [CNT_W:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt <= '0;
    else if (busy_q) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  p_ack_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (hi_cnt == (CNT_W+1)'(CALL_CYC)));

  p_vec_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (vec_q == '0));

  p_vec_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (vec_q[0] == 1'b0 && vec_q >= VEC_W'(2) && vec_q <= VEC_W'(2 * NUM_SRC)));

  p_take_gie_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !gie_q);

  p_di_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !gie_q);

  p_ei_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !di_i && !gie_q) |=> gie_q);

  p_no_take_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_q && !busy_q) |=> !busy_q);

  p_vec_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> $stable(vec_q));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               reg_we_i,
  input  logic               reg_sel_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               boundary_i,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               reti_i,
  output logic               ack_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [DATA_W-1:0]  status_o
);
  logic [NUM_SRC-1:0] pend, en, req, grant, clr;
  logic               any, gie;
  logic [VEC_W-1:0]   win_vec;

  vic_pending u_pending (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt_i),
    .clr_i (clr),
    .pend_o(pend)
  );

  vic_enable_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .sel_i  (reg_sel_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .en_o   (en)
  );

  assign req = pend & en;

  vic_prio u_prio (
    .req_i  (req),
    .grant_o(grant),
    .any_o  (any),
    .vec_o  (win_vec)
  );

  vic_ack_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .boundary_i(boundary_i),
    .ei_i      (ei_i),
    .di_i      (di_i),
    .reti_i    (reti_i),
    .any_i     (any),
    .grant_i   (grant),
    .win_vec_i (win_vec),
    .gie_o     (gie),
    .busy_o    (ack_o),
    .clr_o     (clr),
    .vec_o     (vec_o)
  );

  always_comb begin
    status_o            = '0;
    status_o[SENSE_BIT] = any;
    status_o[GIE_BIT]   = gie;
  end

  p_clr_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr));

  p_clr_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr) |-> (((clr & pend & en) == clr) && gie && boundary_i));
endmodule

// File: tb/vic_top_tb.sv
module vic_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] evt_i = '0;
  logic        reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        boundary_i = 1'b0, ei_i = 1'b0, di_i = 1'b0, reti_i = 1'b0;
  logic        ack_o;
  logic [15:0] vec_o;
  logic [7:0]  status_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  vic_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
    .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .boundary_i(boundary_i), .ei_i(ei_i),
    .di_i(di_i), .reti_i(reti_i), .ack_o(ack_o), .vec_o(vec_o),
    .status_o(status_o)
  );

  localparam int NT = 10;
  localparam logic [10:0] T_EVT [NT] = '{11'h7FF, 11'h7FF, 11'h108, 11'h108, 11'h400,
                                         11'h400, 11'h020, 11'h040, 11'h000, 11'h014};
  localparam logic [7:0]  T_GEN [NT] = '{8'hFF, 8'hFE, 8'hFF, 8'hFF, 8'h80,
                                         8'h7F, 8'h00, 8'h08, 8'hFF, 8'h04};
  localparam logic [7:0]  T_EP  [NT] = '{8'h07, 8'h07, 8'h07, 8'h00, 8'h00,
                                         8'h00, 8'h04, 8'h00, 8'h07, 8'h02};
  localparam logic [15:0] T_VEC [NT] = '{16'h0002, 16'h0004, 16'h0008, 16'h0012, 16'h0016,
                                         16'h0000, 16'h000C, 16'h000E, 16'h0000, 16'h0006};

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; tick(); tick();
    rst_ni = 1'b1; tick();
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d; tick();
    reg_we_i = 1'b0; reg_sel_i = 1'b0;
  endtask

  task automatic pulse_evt(logic [10:0] m);
    evt_i = m; tick(); evt_i = '0;
  endtask

  task automatic do_ei();  ei_i = 1'b1; tick(); ei_i = 1'b0; endtask
  task automatic do_bnd(); boundary_i = 1'b1; tick(); boundary_i = 1'b0; endtask
  task automatic wait_idle(); repeat (12) tick(); endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt;
    // R3: reset state
    rst_ni = 1'b0; tick();
    chk("R3 ack in reset", ack_o, 0);
    chk("R3 vec in reset", vec_o, 0);
    chk("R3 status in reset", status_o, 0);
    rst_ni = 1'b1; tick();
    chk("R3 gen reg after reset", reg_rdata_o, 0);
    reg_sel_i = 1'b1; tick();
    chk("R3 ep reg after reset", reg_rdata_o, 0);
    reg_sel_i = 1'b0;

    // vector table: R2 R4 R5 R6 R9 R11
    for (int i = 0; i < NT; i++) begin
      do_reset();
      wr(1'b0, T_GEN[i]);
      wr(1'b1, T_EP[i]);
      pulse_evt(T_EVT[i]);
      do_ei();
      chk("R9 sense before ack", status_o[7], (T_VEC[i] != 0));
      chk("R8 gie after ei", status_o[2], 1);
      do_bnd();
      chk("R6 ack start", ack_o, (T_VEC[i] != 0));
      chk("R4 R5 vector", vec_o, T_VEC[i]);
      chk("R6 gie cleared on ack", status_o[2], (T_VEC[i] == 0));
      wait_idle();
    end

    // R7 length, R11 boundary during ack
    do_reset();
    wr(1'b0, 8'hFF);
    pulse_evt(11'h003);
    do_ei();
    do_bnd();
    cnt = 0;
    while (ack_o && cnt < 20) begin
      cnt++;
      if (cnt == 3) begin
        boundary_i = 1'b1; tick(); boundary_i = 1'b0;
        chk("R11 vec held during ack", vec_o, 16'h0002);
      end else tick();
    end
    chk("R7 ack length", cnt, 10);
    chk("R7 vec zero when idle", vec_o, 0);
    chk("R6 gie off after ack", status_o[2], 0);
    chk("R9 sense with gie off", status_o[7], 1);
    do_bnd();
    chk("R11 no ack with gie off", ack_o, 0);
    reti_i = 1'b1; tick(); reti_i = 1'b0;
    chk("R8 reti sets gie", status_o[2], 1);
    do_bnd();
    chk("R1 remaining source acked", vec_o, 16'h0004);
    wait_idle();
    chk("R9 sense clear when none pending", status_o[7], 0);

    // R8 DI priority
    ei_i = 1'b1; di_i = 1'b1; tick(); ei_i = 1'b0; di_i = 1'b0;
    chk("R8 di beats ei", status_o[2], 0);
    do_ei();
    chk("R8 ei sets gie", status_o[2], 1);
    di_i = 1'b1; tick(); di_i = 1'b0;
    chk("R8 di clears gie", status_o[2], 0);

    // R10 event collides with its own clear
    do_reset();
    wr(1'b0, 8'h01);
    pulse_evt(11'h001);
    do_ei();
    boundary_i = 1'b1; evt_i = 11'h001; tick();
    boundary_i = 1'b0; evt_i = '0;
    chk("R10 ack taken", vec_o, 16'h0002);
    wait_idle();
    chk("R10 flag survives", status_o[7], 1);
    reti_i = 1'b1; tick(); reti_i = 1'b0;
    do_bnd();
    chk("R10 reacknowledged", vec_o, 16'h0002);
    wait_idle();

    // R1 R2 pending while disabled, late enable
    do_reset();
    pulse_evt(11'h008);
    do_ei();
    chk("R2 disabled no sense", status_o[7], 0);
    do_bnd();
    chk("R2 disabled no ack", ack_o, 0);
    wr(1'b1, 8'h01);
    chk("R1 pending kept while disabled", status_o[7], 1);
    do_bnd();
    chk("R1 late enable vector", vec_o, 16'h0008);
    wait_idle();

    // R2 readback
    wr(1'b0, 8'hA5);
    chk("R2 gen readback", reg_rdata_o, 8'hA5);
    wr(1'b1, 8'hFF);
    reg_sel_i = 1'b1; tick();
    chk("R2 ep readback", reg_rdata_o, 8'h07);
    reg_sel_i = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule